// File: doc/BRIEF.md
# Multiplied-Toggle Wide Pulse Generator

This block drives a bank of vertical timing outputs with pulses that can be far wider than one horizontal line. Each output has a starting level and three toggle points. In normal operation a toggle point is a pixel count. In wide mode the same toggle value is scaled by a multiplier, so an edge lands at value × multiplier pixels after the start strobe. The shared length field supplies that multiplier.

Internally a prescaler divides the pixel clock by the multiplier, and a coarse counter counts prescaler wraps. All comparisons are made on the coarse counter. Edges therefore fall only on multiplier-sized steps, but a 12-bit toggle value times a 10-bit multiplier reaches millions of pixels. A repetition value marks the end of the pattern. At that point an end flag pulses and every output keeps its last level until the next start.

Top module: `wide_pulse_gen`

## Requirements
- R1: While reset is asserted (active low), every output in `vout` is 0 and `done` is 0. The block stays idle until the first start strobe.
- R2: When `start` is high at a clock edge, the pattern restarts. From that edge (pixel 0), bit i of `vout` equals bit i of `start_pol`. This also applies when `start` arrives while a pattern is running.
- R3: With `wide_en` = 0 the multiplier is ignored. Output i inverts at pixel t for each of its nonzero toggle values t, where pixel p is the p-th clock edge after the start edge.
- R4: With `wide_en` = 1 and multiplier M ≥ 1, output i inverts at pixel t × M. A pulse may span thousands of pixels.
- R5: Outputs change only at pixels that are whole multiples of the effective multiplier, so edge resolution equals the multiplier.
- R6: A toggle value of 0 never causes an edge. Two equal toggle values on one output cancel: each match inverts the output, so an even number of matches leaves it unchanged.
- R7: `done` is high for exactly one cycle, at pixel rep × M (M is 1 when `wide_en` = 0). A toggle equal to rep still takes effect at that pixel. Toggle values greater than rep never take effect.
- R8: After the end pixel, `vout` holds its level until the next start strobe.
- R9: With `wide_en` = 1, a multiplier of 0 behaves exactly like a multiplier of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; the edge that samples it high is pixel 0 |
| wide_en | input | 1 | 1 selects scaled toggle positions |
| mult | input | 10 | Multiplier (length field) |
| rep_val | input | 12 | Coarse count at which the pattern ends |
| start_pol | input | 6 | Starting level of each output |
| tog_a | input | 6×12 | First toggle value of each output |
| tog_b | input | 6×12 | Second toggle value of each output |
| tog_c | input | 6×12 | Third toggle value of each output |
| vout | output | 6 | Vertical timing outputs |
| done | output | 1 | One-cycle end-of-pattern flag |

## Verification
Both `vout` and `done` are registered, with no further latency. An edge due at pixel p is therefore visible just after the p-th rising edge that follows the edge capturing `start`. The bench raises `start` at a falling edge and counts falling edges from there. At each falling edge it compares `vout` and `done` against a model of the requirements evaluated at that pixel. This checks exact edge placement, the absence of edges between steps, the one-cycle end flag and the hold afterwards. Runs extend past the end pixel, and one scenario restarts the pattern mid-run.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int unsigned WPG_LANES = 6;
  localparam int unsigned WPG_TOG_W = 12;
  localparam int unsigned WPG_MUL_W = 10;

  typedef enum logic {
    WPG_IDLE = 1'b0,
    WPG_RUN  = 1'b1
  } wpg_state_e;
endpackage

// File: rtl/wpg_prescaler.sv
module wpg_prescaler #(
  parameter int unsigned MUL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             running,
  input  logic             wide_en,
  input  logic [MUL_W-1:0] mult,
  output logic             step
);
  logic [MUL_W-1:0] cnt_q, cnt_d;
  logic [MUL_W-1:0] mult_eff;
  logic             wrap;

  // zero multiplier is treated as one; narrow mode always steps every pixel
  always_comb begin
    if (!wide_en || (mult == '0)) mult_eff = MUL_W'(1);
    else                          mult_eff = mult;
  end

  assign wrap = (cnt_q == (mult_eff - MUL_W'(1)));
  assign step = running && wrap && !load;

  always_comb begin
    cnt_d = cnt_q;
    if (load)         cnt_d = '0;
    else if (running) cnt_d = wrap ? '0 : (cnt_q + MUL_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < mult_eff)); // R5
  AST_PRESC_ZERO_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/wpg_coarse_ctr.sv
module wpg_coarse_ctr
  import wpg_pkg::*;
#(
  parameter int unsigned TOG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [TOG_W-1:0] rep_val,
  output logic [TOG_W-1:0] coarse_nxt,
  output logic             running,
  output logic             done
);
  logic [TOG_W-1:0] coarse_q, coarse_d;
  wpg_state_e       state_q, state_d;
  logic             done_d;
  logic             at_end;

  assign coarse_nxt = coarse_q + TOG_W'(1);
  assign at_end     = step && (coarse_nxt == rep_val);
  assign running    = (state_q == WPG_RUN);

  always_comb begin
    coarse_d = coarse_q;
    state_d  = state_q;
    done_d   = 1'b0;
    if (load) begin
      coarse_d = '0;
      state_d  = WPG_RUN;
    end else if (step) begin
      coarse_d = coarse_nxt;
      if (at_end) begin
        state_d = WPG_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      state_q  <= WPG_IDLE;
      done     <= 1'b0;
    end else begin
      coarse_q <= coarse_d;
      state_q  <= state_d;
      done     <= done_d;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running); // R8
  AST_COARSE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load) |=> ((coarse_q == $past(coarse_q)) ||
                            (coarse_q == $past(coarse_q) + TOG_W'(1)))); // R5
endmodule

// File: rtl/wpg_lane.sv
module wpg_lane #(
  parameter int unsigned TOG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             pol,
  input  logic [TOG_W-1:0] coarse_nxt,
  input  logic [TOG_W-1:0] tog_a,
  input  logic [TOG_W-1:0] tog_b,
  input  logic [TOG_W-1:0] tog_c,
  output logic             level
);
  logic hit_a, hit_b, hit_c, flip, level_d;

  // a zero toggle value never matches
  assign hit_a = (tog_a != '0) && (coarse_nxt == tog_a);
  assign hit_b = (tog_b != '0) && (coarse_nxt == tog_b);
  assign hit_c = (tog_c != '0) && (coarse_nxt == tog_c);
  assign flip  = step && (hit_a ^ hit_b ^ hit_c);

  always_comb begin
    level_d = level;
    if (load)      level_d = pol;
    else if (flip) level_d = ~level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else        level <= level_d;
  end

  AST_LOAD_POL: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (level == $past(pol))); // R2
  AST_NO_EDGE_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(level)); // R5
endmodule

// File: rtl/wide_pulse_gen.sv
module wide_pulse_gen
  import wpg_pkg::*;
#(
  parameter int unsigned LANES = WPG_LANES,
  parameter int unsigned TOG_W = WPG_TOG_W,
  parameter int unsigned MUL_W = WPG_MUL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        wide_en,
  input  logic [MUL_W-1:0]            mult,
  input  logic [TOG_W-1:0]            rep_val,
  input  logic [LANES-1:0]            start_pol,
  input  logic [LANES-1:0][TOG_W-1:0] tog_a,
  input  logic [LANES-1:0][TOG_W-1:0] tog_b,
  input  logic [LANES-1:0][TOG_W-1:0] tog_c,
  output logic [LANES-1:0]            vout,
  output logic                        done
);
  logic             step;
  logic             running;
  logic [TOG_W-1:0] coarse_nxt;

  wpg_prescaler #(.MUL_W(MUL_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .running (running),
    .wide_en (wide_en),
    .mult    (mult),
    .step    (step)
  );

  wpg_coarse_ctr #(.TOG_W(TOG_W)) u_coarse (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .step       (step),
    .rep_val    (rep_val),
    .coarse_nxt (coarse_nxt),
    .running    (running),
    .done       (done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wpg_lane #(.TOG_W(TOG_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start),
      .step       (step),
      .pol        (start_pol[g]),
      .coarse_nxt (coarse_nxt),
      .tog_a      (tog_a[g]),
      .tog_b      (tog_b[g]),
      .tog_c      (tog_c[g]),
      .level      (vout[g])
    );
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(vout) && !done)); // R8
endmodule

// File: tb/sim_wide_pulse_gen.sv
`timescale 1ns/1ps
module sim_wide_pulse_gen;
  localparam int LANES = 6;
  localparam int TW = 12;
  localparam int MW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic start, wide_en;
  logic [MW-1:0] mult;
  logic [TW-1:0] rep_val;
  logic [LANES-1:0] start_pol;
  logic [LANES-1:0][TW-1:0] tog_a, tog_b, tog_c;
  logic [LANES-1:0] vout;
  logic done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wide_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_en(wide_en),
    .mult(mult), .rep_val(rep_val), .start_pol(start_pol),
    .tog_a(tog_a), .tog_b(tog_b), .tog_c(tog_c),
    .vout(vout), .done(done)
  );

  function automatic int eff_mult();
    if (!wide_en || mult == 0) return 1;
    return int'(mult);
  endfunction

  function automatic logic [LANES-1:0] model_v(int p);
    logic [LANES-1:0] r;
    int m;
    m = eff_mult();
    r = start_pol;
    for (int i = 0; i < LANES; i++) begin
      int t[3];
      t[0] = int'(tog_a[i]); t[1] = int'(tog_b[i]); t[2] = int'(tog_c[i]);
      for (int k = 0; k < 3; k++)
        if (t[k] != 0 && t[k] <= int'(rep_val) && t[k] * m <= p) r[i] = ~r[i];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_lane(int i, int a, int b, int c);
    tog_a[i] = TW'(a); tog_b[i] = TW'(b); tog_c[i] = TW'(c);
  endtask

  task automatic clear_lanes();
    for (int i = 0; i < LANES; i++) set_lane(i, 0, 0, 0);
  endtask

  // starts a pattern and checks every pixel 0..n against the model
  task automatic run_case(string tag, int n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int p = 0; p <= n; p++) begin
      if (p > 0) @(negedge clk);
      chk({tag, " vout"}, 32'(vout), 32'(model_v(p)));
      chk({tag, " done"}, 32'(done), 32'(p == int'(rep_val) * eff_mult()));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; wide_en = 1'b0; mult = '0;
    rep_val = '0; start_pol = '0; clear_lanes();
    repeat (3) @(negedge clk);
    chk("R1 vout in reset", 32'(vout), 0);
    chk("R1 done in reset", 32'(done), 0);
    rst_n = 1'b1;
    start_pol = 6'h3F;
    repeat (4) @(negedge clk);
    chk("R1 idle before start", 32'(vout), 0);
  endtask

  task automatic t_narrow();
    wide_en = 1'b0; mult = 10'd7; rep_val = 12'd12; start_pol = 6'b010101;
    set_lane(0, 2, 5, 9); set_lane(1, 1, 3, 0); set_lane(2, 4, 0, 0);
    set_lane(3, 6, 7, 8); set_lane(4, 11, 0, 0); set_lane(5, 3, 10, 12);
    run_case("R3 R2 narrow", 20);
  endtask

  task automatic t_wide();
    wide_en = 1'b1; mult = 10'd4; rep_val = 12'd10; start_pol = 6'b110010;
    set_lane(0, 1, 2, 3); set_lane(1, 5, 0, 0); set_lane(2, 2, 9, 0);
    set_lane(3, 4, 6, 10); set_lane(4, 7, 0, 0); set_lane(5, 3, 8, 0);
    run_case("R4 R5 wide m4", 50);
  endtask

  task automatic t_zero_equal();
    wide_en = 1'b1; mult = 10'd3; rep_val = 12'd9; start_pol = 6'b000000;
    set_lane(0, 0, 0, 0); set_lane(1, 4, 4, 0); set_lane(2, 4, 4, 4);
    set_lane(3, 0, 2, 0); set_lane(4, 5, 0, 5); set_lane(5, 0, 0, 7);
    run_case("R6 zero and equal toggles", 35);
  endtask

  task automatic t_mult_zero();
    wide_en = 1'b1; mult = 10'd0; rep_val = 12'd8; start_pol = 6'b101010;
    set_lane(0, 1, 0, 0); set_lane(1, 2, 6, 0); set_lane(2, 3, 0, 0);
    set_lane(3, 8, 0, 0); set_lane(4, 5, 7, 0); set_lane(5, 4, 0, 0);
    run_case("R9 mult zero as one", 14);
  endtask

  task automatic t_end_beyond();
    wide_en = 1'b1; mult = 10'd5; rep_val = 12'd6; start_pol = 6'b001100;
    set_lane(0, 6, 0, 0); set_lane(1, 7, 0, 0); set_lane(2, 3, 20, 0);
    set_lane(3, 2, 6, 9); set_lane(4, 100, 0, 0); set_lane(5, 1, 0, 0);
    run_case("R7 R8 end and hold", 60);
  endtask

  task automatic t_long();
    wide_en = 1'b1; mult = 10'd1023; rep_val = 12'd6; start_pol = 6'b000001;
    set_lane(0, 2, 5, 0); set_lane(1, 1, 6, 0); set_lane(2, 3, 0, 0);
    set_lane(3, 4, 0, 0); set_lane(4, 0, 0, 0); set_lane(5, 1, 2, 3);
    run_case("R4 long pulse", 6200);
  endtask

  task automatic t_restart();
    wide_en = 1'b1; mult = 10'd2; rep_val = 12'd10; start_pol = 6'b011011;
    set_lane(0, 1, 0, 0); set_lane(1, 2, 0, 0); set_lane(2, 3, 0, 0);
    set_lane(3, 4, 0, 0); set_lane(4, 5, 0, 0); set_lane(5, 6, 0, 0);
    run_case("R2 restart first run", 7);
    run_case("R2 restart second run", 26);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_zero_equal();
    t_mult_zero();
    t_end_beyond();
    t_long();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule